// File: doc/BRIEF.md
# I2C Register-Write Target

This block is a bus target that lets an external I2C controller fill a bank of 8-bit control registers. SCL and SDA are oversampled with the system clock, which must run at least eight times faster than SCL. The block detects START and STOP conditions and checks the first byte for a fixed 7-bit device address with a write direction bit. It then takes a register address byte that loads an internal pointer. Every following data byte is stored at the pointer, and the pointer then steps forward by one.

The block answers only write requests. It acknowledges a byte by pulling SDA low through an output enable, and it never drives SDA high. The register contents are available to the rest of the chip as one flat parallel vector, with register `n` on bits `[8n+7:8n]`. The block does not return data to the controller, does not stretch the clock, and handles neither 10-bit addressing nor general calls.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset every register reads 0x00 on `reg_bank_o` and `sda_pull_o` is 0.
- R2: A STOP (SDA rising while SCL is high) at any point returns the block to idle. A data byte cut short by a STOP is not stored and does not move the pointer.
- R3: A first byte of 0x24 (device address 7'h12 in bits [7:1], bit 0 = 0 for write) is acknowledged: `sda_pull_o` goes high while SCL is low and stays high through the ninth SCL pulse.
- R4: A first byte whose bits [7:1] differ from 7'h12 is not acknowledged. Until the next START, no later byte is acknowledged and no register changes.
- R5: A first byte of 0x25 (the read direction) is not acknowledged, and the rest of the transaction is ignored.
- R6: The register-address byte is always acknowledged. Its bit 7 is ignored, so only bits [6:0] select the register (0x85 selects register 0x05).
- R7: A register-address byte with bits [6:0] above 0x4F is acknowledged but leaves the pointer unchanged. The next data byte goes to the pointer's previous value.
- R8: Each data byte, received MSB first, is written to the register the pointer selects and is acknowledged.
- R9: After each stored data byte the pointer increments by one, so a burst fills consecutive registers.
- R10: When a data byte is stored at 0x4F, the pointer wraps to 0x00 and the burst continues from register 0x00.
- R11: A repeated START in the middle of a byte drops that partial byte and restarts device-address reception.
- R12: `sda_pull_o` is 0 while the controller is sending bits. It is released within a few system clocks after the falling SCL edge that ends the acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus (wired-AND level) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_bank_o | output | NUM_REGS*8 | All registers; register n on bits [8n+7:8n] |

## Verification
The write path is tested with several transaction shapes. A single-byte write shows that bytes are assembled MSB first. A three-byte burst shows the pointer stepping. A burst starting at 0x4E shows the wrap to 0x00 and that the wrapped writes overwrite earlier registers. Other transactions check the address handling: a register-address byte with bit 7 set must hit the masked register, and an out-of-range address must leave the pointer where it was. A wrong device address and a read request check the no-acknowledge and ignore paths. A repeated START and a STOP, each arriving partway through a data byte, check that partial bytes are dropped. A write after the aborted STOP shows whether the pointer moved. A scoreboard pairs every register change seen at the output with an expected write, so a write that should not happen is caught as well as a missing one.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } eng_state_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_hi,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic scl_prev_q, sda_prev_q;
  logic scl_s, sda_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign scl_pipe_d = scl_i;
      assign sda_pipe_d = sda_i;
    end else begin : g_many
      assign scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      assign sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
    end
  endgenerate

  assign scl_s = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s = sda_pipe_q[SYNC_STAGES-1];

  // Idle bus level is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_hi    = scl_s;
  assign sda_hi    = sda_s;
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & ~sda_s & sda_prev_q;
  assign stop_det  = scl_s & scl_prev_q & sda_s & ~sda_prev_q;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_regwr_pkg::*;
#(
  parameter logic [IDX_W-1:0] DEV_ADDR = 7'h12,
  parameter logic [IDX_W-1:0] LAST_REG = 7'h4F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_hi,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              ptr_load,
  output logic [IDX_W-1:0]  ptr_val,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              idle_o,
  output logic              skip_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  eng_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              pull_q, pull_d;
  logic              recv_state;
  logic              byte_done;

  assign recv_state = (state_q == ST_DEV) || (state_q == ST_REG) || (state_q == ST_DATA);
  assign byte_done  = recv_state && scl_fall && (cnt_q == FULL);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    shift_d  = shift_q;
    pull_d   = pull_q;
    ptr_load = 1'b0;
    ptr_val  = shift_q[IDX_W-1:0];
    wr_en    = 1'b0;
    wr_data  = shift_q;
    if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else begin
      if (recv_state && scl_rise && (cnt_q != FULL)) begin
        shift_d = {shift_q[BYTE_W-2:0], sda_hi};
        cnt_d   = cnt_q + 1'b1;
      end
      if (byte_done) begin
        cnt_d = '0;
        unique case (state_q)
          ST_DEV: begin
            if ((shift_q[BYTE_W-1:1] == DEV_ADDR) && !shift_q[0]) begin
              state_d = ST_DEV_ACK;
              pull_d  = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
          ST_REG: begin
            state_d  = ST_REG_ACK;
            pull_d   = 1'b1;
            ptr_load = (shift_q[IDX_W-1:0] <= LAST_REG);
          end
          ST_DATA: begin
            state_d = ST_DATA_ACK;
            pull_d  = 1'b1;
            wr_en   = 1'b1;
          end
          default: state_d = ST_IDLE;
        endcase
      end
      if (scl_fall && (state_q == ST_DEV_ACK)) begin
        state_d = ST_REG;
        pull_d  = 1'b0;
      end
      if (scl_fall && ((state_q == ST_REG_ACK) || (state_q == ST_DATA_ACK))) begin
        state_d = ST_DATA;
        pull_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      pull_q  <= pull_d;
    end
  end

  assign sda_pull = pull_q;
  assign idle_o   = (state_q == ST_IDLE);
  assign skip_o   = (state_q == ST_SKIP);

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file
  import i2c_regwr_pkg::*;
#(
  parameter int NUM_REGS = 80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ptr_load,
  input  logic [IDX_W-1:0]           ptr_val,
  input  logic                       wr_en,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [IDX_W-1:0]           ptr_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load) begin
      ptr_d = ptr_val;
    end else if (wr_en) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
      logic              cell_we;
      logic [BYTE_W-1:0] cell_q;
      assign cell_we = wr_en && (ptr_q == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cell_q <= '0;
        else if (cell_we) cell_q <= wr_data;
      end
      assign regs_o[g*BYTE_W +: BYTE_W] = cell_q;
    end
  endgenerate

endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter int         NUM_REGS = 80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*BYTE_W-1:0] reg_bank_o
);

  localparam logic [IDX_W-1:0] LAST_REG = IDX_W'(NUM_REGS - 1);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              scl_hi, scl_rise, scl_fall, sda_hi, start_det, stop_det;
  logic              ptr_load, wr_en, eng_idle, eng_skip;
  logic [IDX_W-1:0]  ptr_val, wr_ptr;
  logic [BYTE_W-1:0] wr_data;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  i2c_bus_sync #(.SYNC_STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_hi    (scl_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_hi    (sda_hi),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR), .LAST_REG(LAST_REG)) u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_hi    (sda_hi),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_o),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .idle_o    (eng_idle),
    .skip_o    (eng_skip)
  );

  i2c_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ptr_load (ptr_load),
    .ptr_val  (ptr_val),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ptr_o    (wr_ptr),
    .regs_o   (reg_bank_o)
  );

endmodule

// File: rtl/i2c_regwr_checker.sv
module i2c_regwr_checker #(
  parameter int NUM_REGS = 80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_hi,
  input logic       scl_fall,
  input logic       sda_pull,
  input logic       wr_en,
  input logic [6:0] wr_ptr,
  input logic       eng_idle,
  input logic       eng_skip
);

  localparam logic [6:0] LAST = 7'(NUM_REGS - 1);

  AST_PULL_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_hi); // R3

  AST_PULL_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi)) |-> $stable(sda_pull)); // R12

  AST_PULL_ENDS_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall)); // R12

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_ptr <= LAST)); // R10

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(wr_ptr) == LAST)) |-> (wr_ptr == 7'd0)); // R10

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(wr_ptr) != LAST)) |-> (wr_ptr == 7'($past(wr_ptr) + 7'd1))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> (!sda_pull && !wr_en)); // R2

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_skip |-> (!sda_pull && !wr_en)); // R4

endmodule

bind i2c_regwr_target i2c_regwr_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_hi   (scl_hi),
  .scl_fall (scl_fall),
  .sda_pull (sda_pull_o),
  .wr_en    (wr_en),
  .wr_ptr   (wr_ptr),
  .eng_idle (eng_idle),
  .eng_skip (eng_skip)
);

// File: tb/i2c_regwr_target_bench.sv
module i2c_regwr_target_bench;

  localparam int NREG = 80;
  localparam int Q    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [NREG*8-1:0] bank;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_regwr_target u_i2c_regwr_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .reg_bank_o (bank)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model [NREG];
  int ptr = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  int         exp_addr [$];
  logic [7:0] exp_data [$];
  string      exp_req  [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  // Sends the top n bits of b; checks the target keeps SDA released.
  task automatic send_bits(input logic [7:0] b, input int n);
    bit pulled = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait();
      scl_m = 1'b1; qwait();
      if (sda_pull) pulled = 1'b1;
      qwait();
      scl_m = 1'b0; qwait();
    end
    check(!pulled, "R12", "pull during controller bits", int'(pulled), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic got;
    send_bits(b, 8);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    got = ~sda_line;
    check(got == exp_ack, req, "acknowledge", int'(got), int'(exp_ack));
    qwait();
    scl_m = 1'b0; qwait();
    if (exp_ack) check(sda_pull == 1'b0, "R12", "release after ack", int'(sda_pull), 0);
  endtask

  task automatic push_exp(input int a, input logic [7:0] d, input string req);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_req.push_back(req);
    model[a] = d;
  endtask

  task automatic settle();
    repeat (20) @(posedge clk);
    #1;
  endtask

  // Full write transaction; dev is the first byte on the bus.
  task automatic wr_tx(input logic [7:0] dev, input logic [7:0] ra, input int n,
                       input logic [7:0] base, input string req);
    bit match;
    match = (dev == 8'h24);
    bus_start();
    send_byte(dev, match, match ? "R3" : req);
    send_byte(ra, match, req);
    if (match && (ra[6:0] <= 7'h4F)) ptr = int'(ra[6:0]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = base + 8'(k);
      if (match) begin
        push_exp(ptr, d, req);
        ptr = (ptr == NREG - 1) ? 0 : ptr + 1;
      end
      send_byte(d, match, match ? "R8" : req);
    end
    bus_stop();
    settle();
  endtask

  // Scoreboard monitor: every register change must match the next expected write.
  initial begin
    logic [NREG*8-1:0] prev;
    prev = '0;
    forever begin
      @(negedge clk);
      if (mon_on && (bank != prev)) begin
        for (int i = 0; i < NREG; i++) begin
          if (bank[i*8 +: 8] != prev[i*8 +: 8]) begin
            if (exp_addr.size() == 0) begin
              check(1'b0, "R4", "unexpected write to register", i, -1);
            end else begin
              int a; logic [7:0] d; string r;
              a = exp_addr.pop_front();
              d = exp_data.pop_front();
              r = exp_req.pop_front();
              check(a == i, r, "written register", i, a);
              check(bank[i*8 +: 8] == d, r, "written data", int'(bank[i*8 +: 8]), int'(d));
            end
          end
        end
        prev = bank;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check(bank == '0, "R1", "bank after reset", int'(bank[7:0]), 0);
    check(sda_pull == 1'b0, "R1", "pull after reset", int'(sda_pull), 0);
    mon_on = 1'b1;

    wr_tx(8'h24, 8'h03, 1, 8'hA5, "R8");       // single byte
    wr_tx(8'h24, 8'h10, 3, 8'h31, "R9");       // burst
    wr_tx(8'h24, 8'h4E, 4, 8'hC0, "R10");      // wrap 0x4F -> 0x00
    wr_tx(8'h24, 8'h85, 1, 8'h5A, "R6");       // bit 7 masked, lands at 0x05
    wr_tx(8'h26, 8'h07, 2, 8'h11, "R4");       // wrong device address
    wr_tx(8'h25, 8'h08, 1, 8'h22, "R5");       // read request ignored
    wr_tx(8'h24, 8'h60, 1, 8'h77, "R7");       // out of range: pointer stays at 0x06

    // R11: repeated START in the middle of a data byte
    bus_start();
    send_byte(8'h24, 1'b1, "R11");
    send_byte(8'h20, 1'b1, "R11");
    ptr = 8'h20;
    send_bits(8'hEE, 4);
    bus_start();
    send_byte(8'h24, 1'b1, "R11");
    send_byte(8'h21, 1'b1, "R11");
    ptr = 8'h21;
    push_exp(ptr, 8'h99, "R11");
    ptr = ptr + 1;
    send_byte(8'h99, 1'b1, "R11");
    bus_stop();
    settle();

    // R2: STOP in the middle of a data byte
    bus_start();
    send_byte(8'h24, 1'b1, "R2");
    send_byte(8'h30, 1'b1, "R2");
    ptr = 8'h30;
    send_bits(8'h6C, 5);
    bus_stop();
    settle();
    check(bank[8'h30*8 +: 8] == 8'h00, "R2", "register after aborted byte",
          int'(bank[8'h30*8 +: 8]), 0);
    // Pointer must still be 0x30: an out-of-range address keeps it.
    wr_tx(8'h24, 8'h7F, 1, 8'h44, "R2");

    check(exp_addr.size() == 0, "R9", "expected writes left over", exp_addr.size(), 0);
    for (int i = 0; i < NREG; i++) begin
      check(bank[i*8 +: 8] == model[i], "R8", $sformatf("final register %0d", i),
            int'(bank[i*8 +: 8]), int'(model[i]));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule